// File: doc/BRIEF.md
# Converter Serial Command Port

This block is the slave end of a three-wire serial link that a host uses to configure a multichannel converter and to read back its results. It runs entirely in the system clock domain. The chip select, serial clock and data input pins are synchronised and edge-detected there. Incoming bytes arrive most significant bit first, and each one is sampled on a rising serial clock edge. The outgoing data line changes only on falling edges. Because of this, a host may idle the serial clock either low or high.

The first byte of every transaction is a command. A command whose two top bits are `01` is a setup byte. Bits 5:4 of a setup byte set the conversion clock-mode field. Bits 1:0 decide whether the next byte is a differential-pair mask. Value `10` sends that byte to the unipolar mask, `11` sends it to the bipolar mask, and `00` or `01` sends it nowhere. Any other command byte is ignored. The returned data comes from an external result buffer. The buffer presents its oldest byte, and the block pulses a pop strobe once it has taken that byte.

The receive side is a three-state machine with states `ST_IDLE`, `ST_CMD` and `ST_PAIR`. It has these transitions:
- idle to command, when chip select is seen low;
- command to pair, when a setup byte with a unipolar or bipolar selection completes;
- pair back to command, when the mask byte completes;
- any state back to idle, when chip select is seen high. Any partly received byte is discarded.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset, the clock-mode output is `10`, both pair masks are zero, the output enable is low and no pop is issued.
- R2: A completed command byte whose bits 7:6 are `01` is a setup byte. Its bits 5:4 are copied to the clock-mode output. Bits are received most significant first, one per rising serial clock edge.
- R3: The setup bits 1:0 control the byte that follows. With `10` that byte is written to the unipolar mask. With `11` it is written to the bipolar mask. With `00` or `01` the following byte is decoded as a new command.
- R4: After a mask byte has been written, the next byte in the same transaction is decoded as a command again.
- R5: A command byte whose bits 7:6 are not `01` changes neither the clock mode nor either mask.
- R6: If chip select rises before 8 bits of a byte have arrived, that byte is dropped. The next transaction starts again at a command byte.
- R7: The data output enable is high while chip select is low and low while it is high.
- R8: When chip select falls, the buffer's current byte is loaded so that its most significant bit is on the output before the first rising edge. Later bits advance on falling edges. Successive bytes leave in buffer order, with exactly one pop per byte whose first bit is taken and none for a byte that is loaded but never clocked.
- R9: R2 to R8 hold with the serial clock idling low (sample on rising, shift on falling) and with it idling high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Drive enable for the data output |
| rd_byte | input | 8 | Oldest byte offered by the result buffer |
| rd_pop | output | 1 | One-cycle strobe: the offered byte has been taken |
| clk_mode | output | 2 | Clock-mode field from the last setup byte |
| uni_pairs | output | PAIR_W | Unipolar differential-pair mask |
| bip_pairs | output | PAIR_W | Bipolar differential-pair mask |

## Verification
The hardest case to produce from the ports is the trailing falling edge that idle-low operation leaves after the last bit. That edge loads the next buffer byte without any host ever clocking it. A slip there shows up only as a missing or duplicated byte in the next transaction. The stimulus therefore keeps one running read index across all transactions and alternates the clock idle level between them. Every returned byte is then compared with the buffer model, and so is the total number of pops. A second hard case is a chip-select rise in mid-byte directly after a setup byte that chose a mask. The stimulus sends exactly that and follows it with a setup byte whose value would also be a legal mask. That value lands in the clock mode and not in the mask.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [1:0] SETUP_TAG = 2'b01;
    localparam logic [1:0] CLK_MODE_RST = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_PAIR = 2'd2
    } rx_state_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_s,
    output logic cs_fall,
    output logic sdi_s,
    output logic sclk_rise,
    output logic sclk_fall
);
    logic [STAGES-1:0] cs_q, sclk_q, sdi_q;
    logic cs_d, sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= '1;
            sclk_q <= '0;
            sdi_q  <= '0;
            cs_d   <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            cs_q   <= {cs_q[STAGES-2:0], cs_n};
            sclk_q <= {sclk_q[STAGES-2:0], sclk};
            sdi_q  <= {sdi_q[STAGES-2:0], sdi};
            cs_d   <= cs_q[STAGES-1];
            sclk_d <= sclk_q[STAGES-1];
        end
    end

    assign cs_s      = cs_q[STAGES-1];
    assign cs_fall   = cs_d & ~cs_q[STAGES-1];
    assign sdi_s     = sdi_q[STAGES-1];
    assign sclk_rise = ~sclk_d & sclk_q[STAGES-1];
    assign sclk_fall = sclk_d & ~sclk_q[STAGES-1];
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
    import spi_cfg_pkg::*;
#(
    parameter int PAIR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_rise,
    input  logic              sdi_s,
    output logic [1:0]        clk_mode,
    output logic [PAIR_W-1:0] uni_pairs,
    output logic [PAIR_W-1:0] bip_pairs
);
    rx_state_t state, state_nxt;
    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              tgt_bip;
    logic [BYTE_W-1:0] byte_in;
    logic              byte_done, is_setup;

    assign byte_in   = {shreg, sdi_s};
    assign byte_done = sclk_rise && !cs_s && (state != ST_IDLE)
                       && (cnt == CNT_W'(BYTE_W-1));
    assign is_setup  = (byte_in[7:6] == SETUP_TAG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (!cs_s) state_nxt = ST_CMD;
            ST_CMD: begin
                if (cs_s)                                      state_nxt = ST_IDLE;
                else if (byte_done && is_setup && byte_in[1]) state_nxt = ST_PAIR;
            end
            ST_PAIR: begin
                if (cs_s)           state_nxt = ST_IDLE;
                else if (byte_done) state_nxt = ST_CMD;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            cnt       <= '0;
            tgt_bip   <= 1'b0;
            clk_mode  <= CLK_MODE_RST;
            uni_pairs <= '0;
            bip_pairs <= '0;
        end else if (cs_s || state == ST_IDLE) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (sclk_rise) begin
            shreg <= byte_in[BYTE_W-2:0];
            cnt   <= byte_done ? '0 : cnt + 1'b1;
            if (byte_done) begin
                if (state == ST_CMD && is_setup) begin
                    clk_mode <= byte_in[5:4];
                    tgt_bip  <= byte_in[0];
                end else if (state == ST_PAIR) begin
                    if (tgt_bip) bip_pairs <= byte_in[PAIR_W-1:0];
                    else         uni_pairs <= byte_in[PAIR_W-1:0];
                end
            end
        end
    end

    a_r2_mode_only_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_mode) |-> $past(state) == ST_CMD);
    a_r3_uni_only_from_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(uni_pairs) |-> ($past(state) == ST_PAIR && !$past(tgt_bip)));
    a_r3_bip_only_from_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bip_pairs) |-> ($past(state) == ST_PAIR && $past(tgt_bip)));
    a_r6_cs_rise_idles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> state == ST_IDLE);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              cs_fall,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              rd_pop
);
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            armed  <= 1'b0;
            sdo_oe <= 1'b0;
            rd_pop <= 1'b0;
        end else begin
            rd_pop <= !cs_s && !cs_fall && sclk_rise && (cnt == '0);
            if (cs_s) begin
                cnt    <= '0;
                armed  <= 1'b0;
                sdo_oe <= 1'b0;
            end else begin
                sdo_oe <= 1'b1;
                if (cs_fall) begin
                    sh    <= rd_byte;
                    cnt   <= '0;
                    armed <= 1'b0;
                end else begin
                    if (sclk_rise) begin
                        armed <= 1'b1;
                        cnt   <= (cnt == CNT_W'(BYTE_W-1)) ? '0 : cnt + 1'b1;
                    end
                    if (sclk_fall && armed) begin
                        if (cnt == '0) sh <= rd_byte;
                        else           sh <= {sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sdo = sh[BYTE_W-1];

    a_r8_shift_only_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_fall && !cs_fall) |=> $stable(sh));
    a_r8_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |=> !rd_pop);
    a_r7_oe_off_when_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !sdo_oe);
endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
    import spi_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PAIR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic [7:0]        rd_byte,
    output logic              rd_pop,
    output logic [1:0]        clk_mode,
    output logic [PAIR_W-1:0] uni_pairs,
    output logic [PAIR_W-1:0] bip_pairs
);
    logic cs_s, cs_fall, sdi_s, sclk_rise, sclk_fall;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .cs_s(cs_s), .cs_fall(cs_fall), .sdi_s(sdi_s),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    spi_cmd_decode #(.PAIR_W(PAIR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_rise(sclk_rise),
        .sdi_s(sdi_s), .clk_mode(clk_mode), .uni_pairs(uni_pairs),
        .bip_pairs(bip_pairs)
    );

    spi_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rd_byte(rd_byte),
        .sdo(sdo), .sdo_oe(sdo_oe), .rd_pop(rd_pop)
    );

    a_r1_no_pop_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |-> !rd_pop);
endmodule

// File: tb/adc_cmd_port_tb.sv
module adc_cmd_port_tb;
    localparam int HALF = 8;

    typedef struct packed {
        logic       idle_hi;
        logic [1:0] nb;
        logic [7:0] b0, b1, b2;
        logic [1:0] e_mode;
        logic [7:0] e_uni, e_bip;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{1'b0, 2'd1, 8'h40, 8'h00, 8'h00, 2'b00, 8'h00, 8'h00}, // R2 setup, no mask
        '{1'b1, 2'd2, 8'h72, 8'hA5, 8'h00, 2'b11, 8'hA5, 8'h00}, // R3 unipolar, R9
        '{1'b0, 2'd2, 8'h53, 8'h3C, 8'h00, 2'b01, 8'hA5, 8'h3C}, // R3 bipolar
        '{1'b1, 2'd1, 8'hC3, 8'h00, 8'h00, 2'b01, 8'hA5, 8'h3C}, // R5 unknown tag
        '{1'b0, 2'd3, 8'h00, 8'h62, 8'h0F, 2'b10, 8'h0F, 8'h3C}, // R5 then R3
        '{1'b0, 2'd2, 8'h41, 8'h7B, 8'h00, 2'b11, 8'h0F, 8'h3C}, // R3 sel 01 none
        '{1'b1, 2'd3, 8'h43, 8'h81, 8'h52, 2'b01, 8'h0F, 8'h81}, // R4 cmd after mask
        '{1'b0, 2'd2, 8'h80, 8'h99, 8'h00, 2'b01, 8'h0F, 8'h81}  // R5 two unknown
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, rd_pop;
    logic [7:0] rd_byte;
    logic [1:0] clk_mode;
    logic [7:0] uni_pairs, bip_pairs;
    int pop_idx = 0;
    int rd_cnt = 0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] buf_val(int k);
        return 8'(k * 37 + 5);
    endfunction

    always @(posedge clk) if (rst_n && rd_pop) pop_idx <= pop_idx + 1;
    assign rd_byte = buf_val(pop_idx);

    adc_cmd_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .rd_byte(rd_byte), .rd_pop(rd_pop),
        .clk_mode(clk_mode), .uni_pairs(uni_pairs), .bip_pairs(bip_pairs)
    );

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic spi_begin(logic idle_hi);
        wait_cyc(2);
        sclk = idle_hi;
        wait_cyc(HALF);
        cs_n = 1'b0;
        wait_cyc(HALF);
    endtask

    task automatic spi_end();
        wait_cyc(HALF);
        cs_n = 1'b1;
        wait_cyc(HALF);
    endtask

    task automatic spi_bits(logic idle_hi, logic [7:0] tx, int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (idle_hi) begin
                sclk = 1'b0;
                sdi  = tx[i];
                wait_cyc(HALF);
                rx[i] = sdo;
                sclk = 1'b1;
                wait_cyc(HALF);
            end else begin
                sdi = tx[i];
                wait_cyc(HALF);
                rx[i] = sdo;
                sclk = 1'b1;
                wait_cyc(HALF);
                sclk = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        wait_cyc(4);
        chk("R1 oe in reset", {15'd0, sdo_oe}, 16'd0);
        rst_n = 1'b1;
        wait_cyc(4);
        chk("R1 clk_mode", {14'd0, clk_mode}, 16'h2);
        chk("R1 uni", {8'd0, uni_pairs}, 16'h0);
        chk("R1 bip", {8'd0, bip_pairs}, 16'h0);
        chk("R1 no pop", 16'(pop_idx), 16'd0);

        foreach (VEC[v]) begin
            spi_begin(VEC[v].idle_hi);
            chk("R7 oe with cs low", {15'd0, sdo_oe}, 16'd1);
            for (int b = 0; b < int'(VEC[v].nb); b++) begin
                logic [7:0] tx;
                tx = (b == 0) ? VEC[v].b0 : (b == 1) ? VEC[v].b1 : VEC[v].b2;
                spi_bits(VEC[v].idle_hi, tx, 8, rx);
                chk("R8 R9 readout order", {8'd0, rx}, {8'd0, buf_val(rd_cnt)});
                rd_cnt++;
            end
            spi_end();
            chk("R7 oe with cs high", {15'd0, sdo_oe}, 16'd0);
            chk("R8 pop count", 16'(pop_idx), 16'(rd_cnt));
            chk("R2 clk_mode", {14'd0, clk_mode}, {14'd0, VEC[v].e_mode});
            chk("R3 R4 R5 uni", {8'd0, uni_pairs}, {8'd0, VEC[v].e_uni});
            chk("R3 R4 R5 bip", {8'd0, bip_pairs}, {8'd0, VEC[v].e_bip});
        end

        // R6: setup selects unipolar, mask byte cut short after 4 bits
        spi_begin(1'b0);
        spi_bits(1'b0, 8'h62, 8, rx);
        rd_cnt++;
        spi_bits(1'b0, 8'hFF, 4, rx);
        rd_cnt++;
        spi_end();
        chk("R6 partial mask dropped", {8'd0, uni_pairs}, 16'h0F);
        chk("R6 setup still applied", {14'd0, clk_mode}, 16'h2);
        // R6: next transaction begins at a command, not at the mask
        spi_begin(1'b1);
        spi_bits(1'b1, 8'h70, 8, rx);
        chk("R6 R8 readout after partial", {8'd0, rx}, {8'd0, buf_val(rd_cnt)});
        rd_cnt++;
        spi_end();
        chk("R6 restart as command", {14'd0, clk_mode}, 16'h3);
        chk("R6 uni untouched", {8'd0, uni_pairs}, 16'h0F);
        chk("R8 pop count final", 16'(pop_idx), 16'(rd_cnt));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule